// File: doc/BRIEF.md
# Split-Table Page Walker

This block resolves translation misses for an 18-bit virtual address space made of 512 pages of 512 words. When the translation table misses, the block is given the virtual address, which table missed (user or executive), whether the reference is a write, and whether the request comes from a console or from an address probe. It works out which memory word holds the page entry and reads that word through a valid/ready read port. The word holds two 18-bit entries, and the block picks the one that belongs to the page. It then checks the access and returns one of two results: an expanded entry for the translation table, or a fault indication with a fault word.

User pages are all found in one contiguous map inside the user process table. Executive pages are split into three ranges by page number. Pages below octal 340 and pages from octal 400 up come from the executive process table, each range at its own offset. Pages octal 340 to 377 come from the user process table. The base addresses of both process tables are inputs. The four offsets and the size of installed memory are parameters. If an entry word would lie beyond installed memory, the block does not read memory and reports a non-existent-memory fault.

Top module: `ptw_walker`

## Requirements
- R1: For a user-table miss, the entry word address is user_base + OFS_UMAP + (vpn >> 1), where vpn is vaddr[17:9].
- R2: For an executive miss, the entry word address depends on vpn. If vpn < 0o340, it is exec_base + OFS_X000 + (vpn >> 1). If 0o340 <= vpn < 0o400, it is user_base + OFS_X340 + ((vpn - 0o340) >> 1). Otherwise it is exec_base + OFS_X400 + ((vpn - 0o400) >> 1).
- R3: An odd vpn uses bits 17:0 of the fetched 36-bit word. An even vpn uses bits 35:18.
- R4: In an entry, bit 17 is accessible, bit 16 is writable, bit 15 is software, bit 14 is cacheable, and bits 10:0 are the physical page. Access is granted (rsp_ok=1) only when the accessible bit is set and the reference is a read or the writable bit is set.
- R5: A granted entry gives rsp_entry = {writable, 1'b1, physical page, 9'b0}, with bit 21 = writable and bit 20 = valid. rsp_install is 1 for a granted request unless it came from the console.
- R6: For a walk that read memory, the fault word has bit 35 = virtual reference, bit 34 = user table, bit 33 = write, bit 32 = accessible bit, and bits 17:0 = virtual address. Bit 31 carries the software bit only when the entry is accessible.
- R7: For a probe request, the fault word also carries the writable bit in bit 30 and the cacheable bit in bit 29, and it carries the software bit in bit 31 whether or not the entry is accessible. For other requests, bits 30 and 29 are 0.
- R8: If the entry word address is at or above MEM_WORDS, no memory read is issued and the walk fails with rsp_nxm=1. The fault word then has bit 28 = non-existent memory, bit 27 = physical reference, bit 34 = user table, and bits 19:0 = entry word address.
- R9: A failed walk always returns rsp_entry = 0. rsp_trap is 1 only when the failed request was neither a console request nor a probe.
- R10: req_ready is high only when the block is idle. The memory request stays asserted with a stable address until it is accepted. The response is a single-cycle rsp_valid pulse, and no response comes without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_vaddr | input | 18 | Virtual address that missed |
| req_user | input | 1 | 1 = user table, 0 = executive table |
| req_write | input | 1 | Write reference |
| req_console | input | 1 | Console request (no install, no trap) |
| req_probe | input | 1 | Probe request (extra fault word bits, no trap) |
| exec_base | input | 20 | Executive process table base word address |
| user_base | input | 20 | User process table base word address |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_addr | output | 20 | Entry word address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 36 | Read data |
| rsp_valid | output | 1 | Walk result, one cycle |
| rsp_ok | output | 1 | Access granted |
| rsp_install | output | 1 | Result should be written into the translation table |
| rsp_trap | output | 1 | Page fault must trap |
| rsp_nxm | output | 1 | Entry word lies beyond installed memory |
| rsp_entry | output | 22 | Expanded entry {writable, valid, physical base} |
| rsp_fword | output | 36 | Fault word |

## Verification
Most internal state errors show up on mem_addr or the result of the same walk. A wrong range decision for an executive page or an off-by-one in the address sends the read to the wrong word. That gives the wrong entry contents and a mismatched address one cycle after the request is accepted. A mistake in half selection or in the captured request flags shows up in rsp_entry and rsp_fword on the response pulse for that request. A control state that gets stuck shows as a missing response, or as a read issued for a walk that should have been a non-existent-memory fault. The sweep covers every page number in both tables, reads and writes, the three request kinds, and memory bases placed so that some entry words fall beyond installed memory.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ISSUE,
    S_WAIT,
    S_DONE
  } walk_state_e;

  // bit positions inside an 18-bit page entry
  localparam int ENT_ACC   = 17;
  localparam int ENT_WR    = 16;
  localparam int ENT_SOFT  = 15;
  localparam int ENT_CACHE = 14;

  // bit positions inside the 36-bit fault word
  localparam int FW_VIRT  = 35;
  localparam int FW_USER  = 34;
  localparam int FW_WRITE = 33;
  localparam int FW_ACC   = 32;
  localparam int FW_SOFT  = 31;
  localparam int FW_WPRB  = 30;
  localparam int FW_CPRB  = 29;
  localparam int FW_NXM   = 28;
  localparam int FW_PHYS  = 27;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int          VPN_W    = 9,
  parameter int          PA_W     = 20,
  parameter int unsigned OFS_UMAP = 0,
  parameter int unsigned OFS_X000 = 384,
  parameter int unsigned OFS_X340 = 256,
  parameter int unsigned OFS_X400 = 128,
  parameter int unsigned SPLIT_LO = 224,
  parameter int unsigned SPLIT_HI = 256
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic             user,
  input  logic [PA_W-1:0]  exec_base,
  input  logic [PA_W-1:0]  user_base,
  output logic [PA_W:0]    word_addr
);
  localparam int SW = PA_W + 1;
  localparam logic [VPN_W-1:0] LO = VPN_W'(SPLIT_LO);
  localparam logic [VPN_W-1:0] HI = VPN_W'(SPLIT_HI);

  logic [SW-1:0]    base;
  logic [SW-1:0]    ofs;
  logic [VPN_W-1:0] rel;

  always_comb begin
    if (user) begin
      base = {1'b0, user_base};
      ofs  = SW'(OFS_UMAP);
      rel  = vpn;
    end else if (vpn < LO) begin
      base = {1'b0, exec_base};
      ofs  = SW'(OFS_X000);
      rel  = vpn;
    end else if (vpn < HI) begin
      base = {1'b0, user_base};
      ofs  = SW'(OFS_X340);
      rel  = vpn - LO;
    end else begin
      base = {1'b0, exec_base};
      ofs  = SW'(OFS_X400);
      rel  = vpn - HI;
    end
    word_addr = base + ofs + SW'(rel >> 1);
  end
endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
  import ptw_pkg::*;
#(
  parameter int WORD_W    = 36,
  parameter int VA_W      = 18,
  parameter int PA_W      = 20,
  parameter int PAGE_BITS = 9
) (
  input  logic [WORD_W-1:0] word,
  input  logic              odd,
  input  logic              wr,
  input  logic              con,
  input  logic              prb,
  input  logic              user,
  input  logic [VA_W-1:0]   vaddr,
  input  logic              nxm,
  input  logic [PA_W-1:0]   nxm_addr,
  output logic              ok,
  output logic              install,
  output logic              trap,
  output logic [PA_W+1:0]   entry,
  output logic [WORD_W-1:0] fword
);
  localparam int HALF_W = WORD_W / 2;
  localparam int PPN_W  = PA_W - PAGE_BITS;

  logic [HALF_W-1:0] half;
  logic acc, wbit, sbit, cbit, grant;

  always_comb begin
    half  = odd ? word[HALF_W-1:0] : word[WORD_W-1:HALF_W];
    acc   = half[ENT_ACC];
    wbit  = half[ENT_WR];
    sbit  = half[ENT_SOFT];
    cbit  = half[ENT_CACHE];
    grant = !nxm && acc && (!wr || wbit);

    ok      = grant;
    install = grant && !con;
    trap    = !grant && !con && !prb;

    entry = '0;
    if (grant) entry = {wbit, 1'b1, half[PPN_W-1:0], {PAGE_BITS{1'b0}}};

    fword = '0;
    if (nxm) begin
      fword[FW_NXM]     = 1'b1;
      fword[FW_PHYS]    = 1'b1;
      fword[FW_USER]    = user;
      fword[PA_W-1:0]   = nxm_addr;
    end else begin
      fword[FW_VIRT]    = 1'b1;
      fword[FW_USER]    = user;
      fword[FW_WRITE]   = wr;
      fword[FW_ACC]     = acc;
      fword[FW_SOFT]    = sbit && (acc || prb);
      fword[FW_WPRB]    = prb && wbit;
      fword[FW_CPRB]    = prb && cbit;
      fword[VA_W-1:0]   = vaddr;
    end
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        nxm_now,
  input  logic        mem_req_ready,
  input  logic        mem_rsp_valid,
  output walk_state_e state,
  output logic        cap_req,
  output logic        cap_data
);
  walk_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    cap_req  = 1'b0;
    cap_data = 1'b0;
    unique case (state_q)
      S_IDLE:  if (req_valid) begin
                 cap_req = 1'b1;
                 state_d = nxm_now ? S_DONE : S_ISSUE;
               end
      S_ISSUE: if (mem_req_ready) state_d = S_WAIT;
      S_WAIT:  if (mem_rsp_valid) begin
                 cap_data = 1'b1;
                 state_d  = S_DONE;
               end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int          VA_W      = 18,
  parameter int          PAGE_BITS = 9,
  parameter int          PA_W      = 20,
  parameter int          WORD_W    = 36,
  parameter int unsigned MEM_WORDS = 786432,
  parameter int unsigned OFS_UMAP  = 0,
  parameter int unsigned OFS_X000  = 384,
  parameter int unsigned OFS_X340  = 256,
  parameter int unsigned OFS_X400  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_user,
  input  logic              req_write,
  input  logic              req_console,
  input  logic              req_probe,
  input  logic [PA_W-1:0]   exec_base,
  input  logic [PA_W-1:0]   user_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic              rsp_install,
  output logic              rsp_trap,
  output logic              rsp_nxm,
  output logic [PA_W+1:0]   rsp_entry,
  output logic [WORD_W-1:0] rsp_fword
);
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int unsigned SPLIT_LO = 7 * (1 << (VPN_W - 3)) / 2;  // octal 340 for 9-bit vpn
  localparam int unsigned SPLIT_HI = 1 << (VPN_W - 1);            // octal 400 for 9-bit vpn

  walk_state_e state;
  logic cap_req, cap_data, nxm_now;
  logic [PA_W:0] word_addr_w;

  logic [VA_W-1:0]   vaddr_q;
  logic              user_q, wr_q, con_q, prb_q, nxm_q;
  logic [PA_W-1:0]   addr_q;
  logic [WORD_W-1:0] data_q;

  logic              ok_w, install_w, trap_w;
  logic [PA_W+1:0]   entry_w;
  logic [WORD_W-1:0] fword_w;

  ptw_addr_gen #(
    .VPN_W(VPN_W), .PA_W(PA_W),
    .OFS_UMAP(OFS_UMAP), .OFS_X000(OFS_X000),
    .OFS_X340(OFS_X340), .OFS_X400(OFS_X400),
    .SPLIT_LO(SPLIT_LO), .SPLIT_HI(SPLIT_HI)
  ) i_addr (
    .vpn       (req_vaddr[VA_W-1:PAGE_BITS]),
    .user      (req_user),
    .exec_base (exec_base),
    .user_base (user_base),
    .word_addr (word_addr_w)
  );

  assign nxm_now = word_addr_w >= (PA_W+1)'(MEM_WORDS);

  ptw_ctrl i_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .nxm_now       (nxm_now),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .state         (state),
    .cap_req       (cap_req),
    .cap_data      (cap_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q <= '0;
      user_q  <= 1'b0;
      wr_q    <= 1'b0;
      con_q   <= 1'b0;
      prb_q   <= 1'b0;
      nxm_q   <= 1'b0;
      addr_q  <= '0;
    end else if (cap_req) begin
      vaddr_q <= req_vaddr;
      user_q  <= req_user;
      wr_q    <= req_write;
      con_q   <= req_console;
      prb_q   <= req_probe;
      nxm_q   <= nxm_now;
      addr_q  <= word_addr_w[PA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (cap_data) data_q <= mem_rsp_data;
  end

  ptw_entry_eval #(
    .WORD_W(WORD_W), .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)
  ) i_eval (
    .word     (data_q),
    .odd      (vaddr_q[PAGE_BITS]),
    .wr       (wr_q),
    .con      (con_q),
    .prb      (prb_q),
    .user     (user_q),
    .vaddr    (vaddr_q),
    .nxm      (nxm_q),
    .nxm_addr (addr_q),
    .ok       (ok_w),
    .install  (install_w),
    .trap     (trap_w),
    .entry    (entry_w),
    .fword    (fword_w)
  );

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_ISSUE);
  assign mem_addr      = addr_q;
  assign rsp_valid     = (state == S_DONE);
  assign rsp_ok        = rsp_valid && ok_w;
  assign rsp_install   = rsp_valid && install_w;
  assign rsp_trap      = rsp_valid && trap_w;
  assign rsp_nxm       = rsp_valid && nxm_q;
  assign rsp_entry     = rsp_valid ? entry_w : '0;
  assign rsp_fword     = rsp_valid ? fword_w : '0;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int          PA_W      = 20,
  parameter int          WORD_W    = 36,
  parameter int unsigned MEM_WORDS = 786432
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_console,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [PA_W-1:0]   mem_addr,
  input logic              rsp_valid,
  input logic              rsp_ok,
  input logic              rsp_install,
  input logic              rsp_trap,
  input logic              rsp_nxm,
  input logic [PA_W+1:0]   rsp_entry,
  input logic [WORD_W-1:0] rsp_fword
);
  logic con_seen;
  logic busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      con_seen <= 1'b0;
      busy     <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        con_seen <= req_console;
        busy     <= 1'b1;
      end else if (rsp_valid) begin
        busy     <= 1'b0;
      end
    end
  end

  p_hold_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr));

  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> busy);

  p_fetch_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  p_fetch_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_addr < PA_W'(MEM_WORDS)));

  p_nxm_fails_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_nxm |-> !rsp_ok && rsp_fword[28] && rsp_fword[27]);

  p_fail_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ok |-> rsp_entry == '0);

  p_trap_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> !rsp_ok);

  p_valid_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ok |-> rsp_entry[PA_W]);

  p_no_install_console_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && con_seen |-> !rsp_install);

  p_virt_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ok |-> rsp_fword[35] && rsp_fword[32]);
endmodule

bind ptw_walker ptw_walker_chk #(
  .PA_W(PA_W), .WORD_W(WORD_W), .MEM_WORDS(MEM_WORDS)
) i_ptw_walker_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_console   (req_console),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_addr      (mem_addr),
  .rsp_valid     (rsp_valid),
  .rsp_ok        (rsp_ok),
  .rsp_install   (rsp_install),
  .rsp_trap      (rsp_trap),
  .rsp_nxm       (rsp_nxm),
  .rsp_entry     (rsp_entry),
  .rsp_fword     (rsp_fword)
);

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
  localparam int MEM  = 786432;
  localparam int UMAP = 0;
  localparam int X000 = 384;
  localparam int X340 = 256;
  localparam int X400 = 128;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_user, req_write, req_console, req_probe;
  logic [17:0] req_vaddr;
  logic [19:0] exec_base, user_base;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [19:0] mem_addr;
  logic [35:0] mem_rsp_data;
  logic        rsp_valid, rsp_ok, rsp_install, rsp_trap, rsp_nxm;
  logic [21:0] rsp_entry;
  logic [35:0] rsp_fword;

  int checks = 0;
  int errors = 0;
  bit hung   = 0;

  ptw_walker #(
    .MEM_WORDS(MEM), .OFS_UMAP(UMAP), .OFS_X000(X000),
    .OFS_X340(X340), .OFS_X400(X400)
  ) i_ptw_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_user(req_user), .req_write(req_write), .req_console(req_console),
    .req_probe(req_probe), .exec_base(exec_base), .user_base(user_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_install(rsp_install),
    .rsp_trap(rsp_trap), .rsp_nxm(rsp_nxm), .rsp_entry(rsp_entry), .rsp_fword(rsp_fword)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [35:0] word_of(input logic [19:0] a);
    logic [17:0] l, r;
    l = 18'(a * 20'd2897) ^ 18'h15A3C;
    r = 18'(a * 20'd5171) + 18'h0C3E7;
    return {l, r};
  endfunction

  // memory model: stalls on ready, variable response latency
  logic [2:0]  rdy_ctr;
  logic        pend;
  logic [1:0]  pcnt;
  logic [19:0] paddr, last_addr;
  int          fetches;
  logic [1:0]  lat_cfg;

  assign mem_req_ready = (rdy_ctr != 3'd5) && (rdy_ctr != 3'd2);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_ctr <= '0; pend <= 1'b0; pcnt <= '0; paddr <= '0; last_addr <= '0;
      fetches <= 0; mem_rsp_valid <= 1'b0; mem_rsp_data <= '0;
    end else begin
      rdy_ctr       <= rdy_ctr + 3'd1;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        pend <= 1'b1; pcnt <= lat_cfg; paddr <= mem_addr;
        last_addr <= mem_addr; fetches <= fetches + 1;
      end else if (pend) begin
        if (pcnt == 2'd0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= word_of(paddr);
          pend          <= 1'b0;
        end else begin
          pcnt <= pcnt - 2'd1;
        end
      end
    end
  end

  task automatic chk(input bit good, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // mode: 0 normal, 1 console, 2 probe
  task automatic walk(input int user, input int vpn, input int wr, input int mode);
    logic [17:0] ea;
    int          a, f0, n;
    bit          nxm, acc, wb, sb, cb, ok, con, prb;
    logic [35:0] w, fw;
    logic [17:0] h;
    logic [21:0] ent;
    if (hung) return;
    con = (mode == 1);
    prb = (mode == 2);
    ea  = {vpn[8:0], 9'((vpn * 5 + 3) & 511)};
    if (user != 0)     a = int'(user_base) + UMAP + (vpn >> 1);      // R1
    else if (vpn < 224) a = int'(exec_base) + X000 + (vpn >> 1);     // R2
    else if (vpn < 256) a = int'(user_base) + X340 + ((vpn - 224) >> 1);
    else                a = int'(exec_base) + X400 + ((vpn - 256) >> 1);
    nxm = (a >= MEM);
    fw  = '0;
    ent = '0;
    ok  = 0;
    if (nxm) begin                                                    // R8
      fw[28] = 1; fw[27] = 1; fw[34] = (user != 0); fw[19:0] = 20'(a);
    end else begin
      w   = word_of(20'(a));
      h   = vpn[0] ? w[17:0] : w[35:18];                              // R3
      acc = h[17]; wb = h[16]; sb = h[15]; cb = h[14];
      ok  = acc && ((wr == 0) || wb);                                 // R4
      if (ok) ent = {wb, 1'b1, h[10:0], 9'b0};                        // R5
      fw[35] = 1; fw[34] = (user != 0); fw[33] = (wr != 0); fw[32] = acc;  // R6
      fw[31] = sb && (acc || prb);
      fw[30] = prb && wb; fw[29] = prb && cb;                         // R7
      fw[17:0] = ea;
    end
    f0 = fetches;
    lat_cfg = 2'((vpn + wr) % 4);
    @(negedge clk);
    req_vaddr = ea; req_user = (user != 0); req_write = (wr != 0);
    req_console = con; req_probe = prb; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 40) begin
      @(negedge clk);
      n++;
    end
    if (!rsp_valid) begin
      hung = 1;
      chk(0, "R10 response timeout", 64'(n), 64'd40);
      return;
    end
    chk(rsp_ok == ok, "R4 grant", 64'(rsp_ok), 64'(ok));
    chk(rsp_entry == ent, ok ? "R5 entry" : "R9 zero entry", 64'(rsp_entry), 64'(ent));
    chk(rsp_install == (ok && !con), "R5 install", 64'(rsp_install), 64'(ok && !con));
    chk(rsp_trap == (!ok && !con && !prb), "R9 trap", 64'(rsp_trap), 64'(!ok && !con && !prb));
    chk(rsp_fword == fw, prb ? "R7 probe fault word" : "R6 fault word", 64'(rsp_fword), 64'(fw));
    chk(rsp_nxm == nxm, "R8 nxm flag", 64'(rsp_nxm), 64'(nxm));
    chk((fetches - f0) == (nxm ? 0 : 1), "R8 fetch count", 64'(fetches - f0), 64'(nxm ? 0 : 1));
    if (!nxm)
      chk(last_addr == 20'(a), user != 0 ? "R1 word address" : "R2 word address",
          64'(last_addr), 64'(a));
    @(negedge clk);
    chk(!rsp_valid, "R10 single pulse", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_user = 1'b0;
    req_write = 1'b0; req_console = 1'b0; req_probe = 1'b0;
    exec_base = 20'h01000; user_base = 20'h03000; lat_cfg = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 reset ready", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R10 reset response", 64'(rsp_valid), 64'd0);
    chk(mem_req_valid == 1'b0, "R10 reset fetch", 64'(mem_req_valid), 64'd0);

    // all pages, both tables, reads and writes, rotating request kind
    for (int u = 0; u < 2; u++)
      for (int v = 0; v < 512; v++)
        for (int wr = 0; wr < 2; wr++)
          walk(u, v, wr, (v + u + wr) % 3);

    // bases near the top of memory: part of the entry words do not exist
    exec_base = 20'(MEM - 100);
    user_base = 20'(MEM - 200);
    for (int u = 0; u < 2; u++)
      for (int v = 0; v < 512; v++)
        walk(u, v, v & 1, (v >> 1) % 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule